// File: doc/BRIEF.md
# Six-Stage Instruction Pipeline Timing Sequencer

This block models the timing of an in-order, six-stage instruction pipeline. It carries tokens, not instructions. Each token is an identifier plus a valid bit. A token enters stage one through a valid/ready handshake and leaves stage six through a retire handshake. The fourth stage is the execute stage, and it keeps every token for two clock cycles. No opcode is decoded and no operand is moved: the block only shows how many cycles a stream of tokens takes under each of three issue policies.

A two-bit mode input picks the policy. In serial mode only one token is in flight at a time. In single-execute mode the stages before execute stall while the one execute unit is busy. In dual-execute mode two execute units take successive tokens in turn, and tokens still retire in acceptance order. Back-pressure on the retire side travels backward through every stage in the same cycle.

Two counters are exposed. One counts retired tokens. The other counts the cycles in which any stage holds a token, so after a contiguous stream drains it equals the total run length of that stream. The mode may only change while the block is in reset or empty.

Top module: `pipe_timing_seq`

## Requirements
- R1: A synchronous active-high reset empties every stage and both execute units and clears both counters. In the cycle after reset, `retValid` is 0 and `inReady` is 1.
- R2: Mode codes are 0 for serial, 1 for single-execute and 2 for dual-execute. In every mode, tokens leave on the retire port in exactly the order they were accepted, with their identifiers unchanged.
- R3: The execute stage holds each token for exactly two cycles. A token that is accepted alone and never blocked occupies the pipeline for 7 cycles before it retires, in every mode.
- R4: In mode 0, at most one token is in flight. A new token is accepted only when every other stage is empty and stage six is empty or retiring in that same cycle, so n tokens take 7n cycles.
- R5: In mode 1, stages one to three stall while the single execute unit is busy, so n tokens take 2n+5 cycles.
- R6: In mode 2, successive tokens go to alternate execute units, starting with unit 0 after reset, so n tokens take n+6 cycles.
- R7: In mode 2, stage three holds its token when the unit it would use next is still busy. With retire blocked, the pipeline accepts exactly 7 tokens. The limit is 6 in mode 1 and 1 in mode 0.
- R8: While `retValid` is high and `retReady` is low, the retire token stays unchanged. The stall reaches stage one in the same cycle, so `inReady` falls once the pipeline is full, and no token is lost.
- R9: `retireCount` increments once per retire handshake. `cycleCount` increments once for every cycle in which any stage holds a token, so after a contiguous stream drains it equals the run length of that stream.
- R10: Mode code 3 behaves exactly like mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | Issue policy (0 serial, 1 single-execute, 2 dual-execute, 3 as 1) |
| inValid | input | 1 | A token is offered to stage one |
| inId | input | ID_W | Identifier of the offered token |
| inReady | output | 1 | Stage one accepts the offered token this cycle |
| retValid | output | 1 | Stage six holds a token |
| retId | output | ID_W | Identifier of the stage-six token |
| retReady | input | 1 | Consumer takes the stage-six token this cycle |
| retireCount | output | CNT_W | Number of retired tokens |
| cycleCount | output | CNT_W | Number of cycles with any stage occupied |

## Verification
Two events can fall in the same cycle. In serial mode, stage six retires a token while stage one accepts the next one. In dual-execute mode, an execute unit releases its token and takes a new one from stage three. The bench provokes both cases by streaming tokens back to back with the retire side always ready. It judges them by whether the cycle count matches 7n or n+6 exactly, since a single lost cycle at either handover breaks the formula. A second pass toggles `retReady`, which moves these handovers against a blocked stage six. Retire order and the stability of held tokens are checked on every cycle.

// File: rtl/pipe_timing_pkg.sv
`timescale 1ns/1ps
package pipe_timing_pkg;
  typedef enum logic [1:0] {
    MODE_SERIAL = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_ALIAS  = 2'd3
  } modeT;

  typedef struct packed {
    logic accept;
    logic s1Go;
    logic s2Go;
    logic s3Go;
    logic dispUnit;
    logic exGo;
    logic exUnit;
    logic s5Go;
    logic s6Go;
  } strobeT;
endpackage

// File: rtl/pipe_timing_slot.sv
`timescale 1ns/1ps
module pipe_timing_slot #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            clear,
  input  logic [ID_W-1:0] dIn,
  output logic            vOut,
  output logic [ID_W-1:0] idOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vOut  <= 1'b0;
      idOut <= '0;
    end else if (load) begin
      vOut  <= 1'b1;
      idOut <= dIn;
    end else if (clear) begin
      vOut  <= 1'b0;
    end
  end
endmodule

// File: rtl/pipe_timing_ctrl.sv
`timescale 1ns/1ps
module pipe_timing_ctrl
  import pipe_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       inValid,
  input  logic       retReady,
  input  logic       s1Valid,
  input  logic       s2Valid,
  input  logic       s3Valid,
  input  logic [1:0] unitValid,
  input  logic [1:0] unitDone,
  input  logic       s5Valid,
  input  logic       s6Valid,
  output logic       inReady,
  output strobeT     strb
);
  logic dispPtr, exitPtr;
  logic dualMode, serialMode;
  logic s6Free, s5Free, s3Free, s2Free, s1Free, unitFree, upstreamEmpty;

  assign dualMode   = (modeSel == MODE_DUAL);
  assign serialMode = (modeSel == MODE_SERIAL);

  // Ready flows backward: each stage is free when empty or leaving this cycle.
  always_comb begin
    strb          = '0;
    strb.s6Go     = s6Valid & retReady;
    s6Free        = ~s6Valid | retReady;
    strb.s5Go     = s5Valid & s6Free;
    s5Free        = ~s5Valid | strb.s5Go;
    strb.exUnit   = dualMode ? exitPtr : 1'b0;
    strb.exGo     = unitValid[strb.exUnit] & unitDone[strb.exUnit] & s5Free;
    strb.dispUnit = dualMode ? dispPtr : 1'b0;
    unitFree      = ~unitValid[strb.dispUnit] |
                    (strb.exGo & (strb.exUnit == strb.dispUnit));
    strb.s3Go     = s3Valid & unitFree;
    s3Free        = ~s3Valid | strb.s3Go;
    strb.s2Go     = s2Valid & s3Free;
    s2Free        = ~s2Valid | strb.s2Go;
    strb.s1Go     = s1Valid & s2Free;
    s1Free        = ~s1Valid | strb.s1Go;
    upstreamEmpty = ~(s1Valid | s2Valid | s3Valid | (|unitValid) | s5Valid);
    inReady       = serialMode ? (upstreamEmpty & (~s6Valid | strb.s6Go)) : s1Free;
    strb.accept   = inValid & inReady;
  end

  // Dispatch and exit pointers walk the units in the same order, keeping retire order.
  always_ff @(posedge clk) begin
    if (rst || !dualMode) begin
      dispPtr <= 1'b0;
      exitPtr <= 1'b0;
    end else begin
      if (strb.s3Go) dispPtr <= ~dispPtr;
      if (strb.exGo) exitPtr <= ~exitPtr;
    end
  end

  // R4: serial policy never has more than one token anywhere.
  p_serial_single_r4: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_SERIAL) |->
      ($countones({s1Valid, s2Valid, s3Valid, unitValid, s5Valid, s6Valid}) <= 1));

  // R7: a dispatch never lands on a unit still computing.
  p_no_busy_dispatch_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.s3Go && unitValid[strb.dispUnit]) |-> unitDone[strb.dispUnit]);
endmodule

// File: rtl/pipe_timing_datapath.sv
`timescale 1ns/1ps
module pipe_timing_datapath
  import pipe_timing_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int CNT_W  = 16,
  parameter int EX_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  strobeT           strb,
  input  logic [ID_W-1:0]  inId,
  input  logic             retReady,
  output logic             s1Valid,
  output logic             s2Valid,
  output logic             s3Valid,
  output logic [1:0]       unitValid,
  output logic [1:0]       unitDone,
  output logic             s5Valid,
  output logic             s6Valid,
  output logic [ID_W-1:0]  retId,
  output logic [CNT_W-1:0] retireCount,
  output logic [CNT_W-1:0] cycleCount
);
  localparam int TW = $clog2(EX_LAT + 1);
  localparam logic [TW-1:0] LAT = TW'(EX_LAT);

  logic [ID_W-1:0] s1Id, s2Id, s3Id, s5Id;
  logic [1:0][ID_W-1:0] unitId;
  logic [1:0][TW-1:0]   unitCnt;
  logic anyValid;

  pipe_timing_slot #(.ID_W(ID_W)) s1_i (.clk(clk), .rst(rst), .load(strb.accept),
    .clear(strb.s1Go), .dIn(inId), .vOut(s1Valid), .idOut(s1Id));
  pipe_timing_slot #(.ID_W(ID_W)) s2_i (.clk(clk), .rst(rst), .load(strb.s1Go),
    .clear(strb.s2Go), .dIn(s1Id), .vOut(s2Valid), .idOut(s2Id));
  pipe_timing_slot #(.ID_W(ID_W)) s3_i (.clk(clk), .rst(rst), .load(strb.s2Go),
    .clear(strb.s3Go), .dIn(s2Id), .vOut(s3Valid), .idOut(s3Id));
  pipe_timing_slot #(.ID_W(ID_W)) s5_i (.clk(clk), .rst(rst), .load(strb.exGo),
    .clear(strb.s5Go), .dIn(unitId[strb.exUnit]), .vOut(s5Valid), .idOut(s5Id));
  pipe_timing_slot #(.ID_W(ID_W)) s6_i (.clk(clk), .rst(rst), .load(strb.s5Go),
    .clear(strb.s6Go), .dIn(s5Id), .vOut(s6Valid), .idOut(retId));

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic loadU, clrU;
    assign loadU = strb.s3Go && (strb.dispUnit == 1'(u));
    assign clrU  = strb.exGo && (strb.exUnit == 1'(u));
    assign unitDone[u] = unitValid[u] && (unitCnt[u] == LAT);

    always_ff @(posedge clk) begin
      if (rst) begin
        unitValid[u] <= 1'b0;
        unitId[u]    <= '0;
        unitCnt[u]   <= '0;
      end else if (loadU) begin
        unitValid[u] <= 1'b1;
        unitId[u]    <= s3Id;
        unitCnt[u]   <= TW'(1);
      end else if (clrU) begin
        unitValid[u] <= 1'b0;
      end else if (unitValid[u] && (unitCnt[u] < LAT)) begin
        unitCnt[u]   <= unitCnt[u] + TW'(1);
      end
    end

    // R3: a unit still counting keeps its token.
    p_unit_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (unitValid[u] && !unitDone[u]) |=> (unitValid[u] && $stable(unitId[u])));
  end

  assign anyValid = s1Valid | s2Valid | s3Valid | (|unitValid) | s5Valid | s6Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      retireCount <= '0;
      cycleCount  <= '0;
    end else begin
      if (strb.s6Go) retireCount <= retireCount + CNT_W'(1);
      if (anyValid)  cycleCount  <= cycleCount + CNT_W'(1);
    end
  end

  // R8: a blocked retire token is held unchanged.
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (s6Valid && !retReady) |=> (s6Valid && $stable(retId)));

  // R9: the retire counter moves only on a handshake.
  p_retire_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(s6Valid && retReady) |=> $stable(retireCount));

  // R1: reset leaves nothing in flight and clears counters.
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!s6Valid && !s1Valid && (unitValid == 2'b00) &&
             retireCount == '0 && cycleCount == '0));
endmodule

// File: rtl/pipe_timing_seq.sv
`timescale 1ns/1ps
module pipe_timing_seq
  import pipe_timing_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int CNT_W  = 16,
  parameter int EX_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       modeSel,
  input  logic             inValid,
  input  logic [ID_W-1:0]  inId,
  output logic             inReady,
  output logic             retValid,
  output logic [ID_W-1:0]  retId,
  input  logic             retReady,
  output logic [CNT_W-1:0] retireCount,
  output logic [CNT_W-1:0] cycleCount
);
  strobeT strb;
  logic s1Valid, s2Valid, s3Valid, s5Valid, s6Valid;
  logic [1:0] unitValid, unitDone;

  pipe_timing_ctrl ctrl_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .inValid(inValid), .retReady(retReady),
    .s1Valid(s1Valid), .s2Valid(s2Valid), .s3Valid(s3Valid), .unitValid(unitValid),
    .unitDone(unitDone), .s5Valid(s5Valid), .s6Valid(s6Valid),
    .inReady(inReady), .strb(strb));

  pipe_timing_datapath #(.ID_W(ID_W), .CNT_W(CNT_W), .EX_LAT(EX_LAT)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .inId(inId), .retReady(retReady),
    .s1Valid(s1Valid), .s2Valid(s2Valid), .s3Valid(s3Valid), .unitValid(unitValid),
    .unitDone(unitDone), .s5Valid(s5Valid), .s6Valid(s6Valid), .retId(retId),
    .retireCount(retireCount), .cycleCount(cycleCount));

  assign retValid = s6Valid;
endmodule

// File: tb/pipe_timing_seq_tb.sv
`timescale 1ns/1ps
module pipe_timing_seq_tb_top;
  localparam int ID_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] modeSel = 2'd0;
  logic inValid = 1'b0;
  logic [ID_W-1:0] inId = '0;
  logic inReady, retValid, retReady;
  logic [ID_W-1:0] retId;
  logic [CNT_W-1:0] retireCount, cycleCount;

  int nChecks = 0;
  int nFails = 0;
  int tick = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pipe_timing_seq #(.ID_W(ID_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .inValid(inValid), .inId(inId),
    .inReady(inReady), .retValid(retValid), .retId(retId), .retReady(retReady),
    .retireCount(retireCount), .cycleCount(cycleCount));

  initial retReady = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 150000);
      summary();
      $finish;
    end
  end

  function automatic int expCycles(input int m, input int n);
    if (m == 0) return 7 * n;        // R4
    else if (m == 2) return n + 6;   // R6
    else return 2 * n + 5;           // R5, R10
  endfunction

  function automatic int capacity(input int m);
    if (m == 0) return 1;
    else if (m == 2) return 7;
    else return 6;
  endfunction

  task automatic doReset(input int m);
    @(negedge clk);
    rst = 1'b1; modeSel = 2'(m); inValid = 1'b0; retReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: empty after reset
    chk(retValid == 1'b0, "R1 retValid", int'(retValid), 0);
    chk(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    chk(retireCount == 0 && cycleCount == 0, "R1 counters", int'(cycleCount), 0);
  endtask

  // pat 0: retire always ready; pat 1: retire blocked one cycle in three
  task automatic stream(input int m, input int n, input int pat);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    bit wasHeld = 1'b0;
    logic [ID_W-1:0] heldId = '0;
    while (got < n && cyc < 2000) begin
      inValid  = (sent < n);
      inId     = ID_W'(sent);
      retReady = (pat == 0) ? 1'b1 : (cyc % 3 != 1);
      #1;
      if (wasHeld) begin
        // R8: blocked token held unchanged
        chk(retValid && retId == heldId, "R8 hold", int'(retId), int'(heldId));
      end
      if (inValid && inReady) sent++;
      if (retValid && retReady) begin
        // R2: retire order equals acceptance order
        chk(retId == ID_W'(got), "R2 order", int'(retId), got);
        got++;
      end
      wasHeld = retValid && !retReady;
      heldId  = retId;
      cyc++;
      @(negedge clk);
    end
    inValid = 1'b0; retReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(int'(retireCount) == n, "R9 retireCount", int'(retireCount), n);
    if (pat == 0)
      chk(int'(cycleCount) == expCycles(m, n), "R9 cycleCount vs mode formula",
          int'(cycleCount), expCycles(m, n));
  endtask

  // R7/R8: with retire blocked the pipeline fills to its capacity, then drains in order.
  task automatic fill(input int m);
    int sent = 0;
    int got = 0;
    retReady = 1'b0;
    for (int c = 0; c < 24; c++) begin
      inValid = 1'b1;
      inId = ID_W'(sent);
      #1;
      if (inReady) sent++;
      @(negedge clk);
    end
    chk(sent == capacity(m), "R7 capacity", sent, capacity(m));
    chk(inReady == 1'b0, "R8 inReady low when full", int'(inReady), 0);
    inValid = 1'b0;
    retReady = 1'b1;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (retValid) begin
        chk(retId == ID_W'(got), "R8 drain order", int'(retId), got);
        got++;
      end
      @(negedge clk);
    end
    chk(got == capacity(m), "R8 no token lost", got, capacity(m));
  endtask

  initial begin
    // R3: a lone token takes 7 cycles in every mode
    for (int m = 0; m < 3; m++) begin
      doReset(m);
      stream(m, 1, 0);
      chk(int'(cycleCount) == 7, "R3 single token span", int'(cycleCount), 7);
    end
    // R4 R5 R6 R10: throughput sweep over every mode code
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 9; n++) begin
        doReset(m);
        stream(m, n, 0);
      end
    end
    // R8: toggling back-pressure, order and holds
    for (int m = 0; m < 4; m++) begin
      doReset(m);
      stream(m, 10, 1);
    end
    // R7: fill limits per mode
    for (int m = 0; m < 3; m++) begin
      doReset(m);
      fill(m);
    end
    // R1: reset in the middle of a dual-mode stream
    doReset(2);
    for (int c = 0; c < 5; c++) begin
      inValid = 1'b1; inId = ID_W'(c);
      @(negedge clk);
    end
    doReset(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule